// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block computes the control-flow outcome of one instruction in a 32-bit core that has a single delay slot after every branch and jump. For each issued instruction it takes the instruction address, a decoded control-flow kind, the low 26 bits of the instruction word, the destination register index and the two source register values. From these it produces the taken decision, the target address, the link write (enable, register index, value) and a fault flag for register-indirect jumps whose target is not word-aligned.

Relative branch targets use the delay-slot address (PC+4) as their base. Absolute jumps keep the top four bits of that same address and replace the rest with the shifted jump index. The return address written by a linking instruction is PC+8, the instruction after the delay slot. The alignment fault is held back by one issued instruction, so that the core traps only after the delay slot has completed.

Top module: `branch_target_unit`

## Requirements
- R1: After reset `alignFault` is 0. While `issueValid` is 0, `taken`, `linkEn` and `alignFault` are 0.
- R2: Kind encodings on `cfKind` are: 0 none, 1 equal, 2 not-equal, 3 less-than-zero, 4 less-or-equal-zero, 5 greater-than-zero, 6 greater-or-equal-zero, 7 less-than-zero-and-link, 8 greater-or-equal-zero-and-link, 9 jump, 10 jump-and-link, 11 register jump, 12 register jump-and-link. Kind 0 is never taken and never links.
- R3: For branch kinds 1–8, `targetPc` = PC + 4 + (sign-extended `instrField[15:0]` shifted left by 2), computed modulo 2^32.
- R4: Kind 1 is taken when rs equals rt, and kind 2 is taken when they differ.
- R5: Kinds 3–8 compare rs with zero as a signed 32-bit integer. Bit 31 set means negative.
- R6: For kinds 9 and 10, `targetPc` = {bits 31:28 of PC+4, `instrField[25:0]`, 2'b00}, and the instruction is always taken.
- R7: For kinds 11 and 12, `targetPc` equals rs, and the instruction is always taken.
- R8: Kinds 7, 8 and 10 set `linkEn` with `linkIdx` = 31 and `linkVal` = PC+8, whether the branch is taken or not.
- R9: Kind 12 links to `destIdx` with `linkVal` = PC+8. When `destIdx` is 0, `linkEn` is 0.
- R10: When kind 11 or 12 issues with rs[1:0] not 00, `alignFault` stays 0 in that cycle. It is 1 on the next cycle with `issueValid` high (the delay slot), with `faultAddr` equal to that rs, and it clears after that cycle. Idle cycles in between keep the fault pending. An aligned rs raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is presented this cycle |
| instrPc | input | 32 | Address of the presented instruction |
| cfKind | input | 4 | Decoded control-flow kind (see R2) |
| instrField | input | 26 | Low 26 bits of the instruction word |
| destIdx | input | 5 | Destination register for register jump-and-link |
| rsVal | input | 32 | First source register value |
| rtVal | input | 32 | Second source register value |
| taken | output | 1 | Control flow transfers after the delay slot |
| targetPc | output | 32 | Transfer address |
| linkEn | output | 1 | Write the return address |
| linkIdx | output | 5 | Register receiving the return address |
| linkVal | output | 32 | Return address (PC+8) |
| alignFault | output | 1 | Misaligned register-jump fault, marked on the delay slot |
| faultAddr | output | 32 | Misaligned target that caused the fault |

## Verification
The bench targets the signed-compare edges: rs = 0, rs = 0x80000000 and rs = 0x7FFFFFFF. An unsigned compare or a wrong inclusive/exclusive boundary flips the taken bit on one of these values. Jumps are issued at the last word below a 256 MB boundary. A design that splices the top bits of PC instead of PC+4 lands in the wrong segment there. Backward and forward offsets expose a missing sign extension or a PC base in place of PC+4.

A not-taken linking branch is included, because a design that gates the link with the condition drops that write. The alignment fault is checked in the jump cycle, across idle cycles and on the delay slot. A fault raised too early, lost while idle or left standing shows up at one of these points.

// File: rtl/btu_pkg.sv
package btu_pkg;
  typedef enum logic [3:0] {
    CF_NONE   = 4'd0,
    CF_EQ     = 4'd1,
    CF_NE     = 4'd2,
    CF_LTZ    = 4'd3,
    CF_LEZ    = 4'd4,
    CF_GTZ    = 4'd5,
    CF_GEZ    = 4'd6,
    CF_LTZ_LK = 4'd7,
    CF_GEZ_LK = 4'd8,
    CF_JMP    = 4'd9,
    CF_JMP_LK = 4'd10,
    CF_REG    = 4'd11,
    CF_REG_LK = 4'd12
  } cf_kind_e;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_REG = 2'd2
  } tgt_sel_e;

  typedef struct packed {
    logic     takeIt;
    tgt_sel_e tgtSel;
    logic     linkWr;
    logic     linkToDest;
    logic     chkAlign;
  } btu_strobe_t;
endpackage

// File: rtl/btu_ctrl.sv
module btu_ctrl
  import btu_pkg::*;
(
  input  logic        issueValid,
  input  logic [3:0]  cfKind,
  input  logic        rsEqRt,
  input  logic        rsNeg,
  input  logic        rsZero,
  input  logic        destZero,
  output btu_strobe_t strobe
);
  logic cond;

  always_comb begin
    cond = 1'b0;
    unique case (cf_kind_e'(cfKind))
      CF_EQ:                cond = rsEqRt;
      CF_NE:                cond = !rsEqRt;
      CF_LTZ, CF_LTZ_LK:    cond = rsNeg;
      CF_LEZ:               cond = rsNeg || rsZero;
      CF_GTZ:               cond = !rsNeg && !rsZero;
      CF_GEZ, CF_GEZ_LK:    cond = !rsNeg;
      CF_JMP, CF_JMP_LK,
      CF_REG, CF_REG_LK:    cond = 1'b1;
      default:              cond = 1'b0;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.tgtSel = TGT_REL;
    if (issueValid) begin
      strobe.takeIt = cond;
      unique case (cf_kind_e'(cfKind))
        CF_JMP, CF_JMP_LK: strobe.tgtSel = TGT_ABS;
        CF_REG, CF_REG_LK: strobe.tgtSel = TGT_REG;
        default:           strobe.tgtSel = TGT_REL;
      endcase
      strobe.linkWr = (cfKind == CF_LTZ_LK) || (cfKind == CF_GEZ_LK) ||
                      (cfKind == CF_JMP_LK) ||
                      ((cfKind == CF_REG_LK) && !destZero);
      strobe.linkToDest = (cfKind == CF_REG_LK);
      strobe.chkAlign   = (cfKind == CF_REG) || (cfKind == CF_REG_LK);
    end
  end
endmodule

// File: rtl/btu_datapath.sv
module btu_datapath
  import btu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [ADDR_W-1:0] instrPc,
  input  logic [IDX_W-1:0]  instrField,
  input  logic [REG_AW-1:0] destIdx,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  input  btu_strobe_t       strobe,
  output logic              rsEqRt,
  output logic              rsNeg,
  output logic              rsZero,
  output logic              destZero,
  output logic [ADDR_W-1:0] targetPc,
  output logic [REG_AW-1:0] linkIdx,
  output logic [ADDR_W-1:0] linkVal,
  output logic              alignFault,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int SEG_W  = ADDR_W - IDX_W - 2;
  localparam int EXT_W  = ADDR_W - OFF_W - 2;
  localparam logic [REG_AW-1:0] LINK_REG = {REG_AW{1'b1}};

  logic [ADDR_W-1:0] slotPc;
  logic [ADDR_W-1:0] relOff;
  logic [ADDR_W-1:0] relTgt;
  logic [ADDR_W-1:0] absTgt;
  logic              faultPend;
  logic [ADDR_W-1:0] faultHold;

  assign rsEqRt   = (rsVal == rtVal);
  assign rsNeg    = rsVal[ADDR_W-1];
  assign rsZero   = (rsVal == '0);
  assign destZero = (destIdx == '0);

  assign slotPc  = instrPc + ADDR_W'(4);
  assign linkVal = instrPc + ADDR_W'(8);
  assign relOff  = {{EXT_W{instrField[OFF_W-1]}}, instrField[OFF_W-1:0], 2'b00};
  assign relTgt  = slotPc + relOff;
  assign absTgt  = {slotPc[ADDR_W-1 -: SEG_W], instrField, 2'b00};

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_ABS: targetPc = absTgt;
      TGT_REG: targetPc = rsVal;
      default: targetPc = relTgt;
    endcase
  end

  always_comb begin
    if (!strobe.linkWr)         linkIdx = '0;
    else if (strobe.linkToDest) linkIdx = destIdx;
    else                        linkIdx = LINK_REG;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPend <= 1'b0;
      faultHold <= '0;
    end else if (issueValid) begin
      faultPend <= strobe.chkAlign && (rsVal[1:0] != 2'b00);
      if (strobe.chkAlign) faultHold <= rsVal;
    end
  end

  assign alignFault = faultPend && issueValid;
  assign faultAddr  = faultHold;
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [ADDR_W-1:0] instrPc,
  input  logic [3:0]        cfKind,
  input  logic [IDX_W-1:0]  instrField,
  input  logic [REG_AW-1:0] destIdx,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  output logic              taken,
  output logic [ADDR_W-1:0] targetPc,
  output logic              linkEn,
  output logic [REG_AW-1:0] linkIdx,
  output logic [ADDR_W-1:0] linkVal,
  output logic              alignFault,
  output logic [ADDR_W-1:0] faultAddr
);
  btu_strobe_t strobe;
  logic rsEqRt, rsNeg, rsZero, destZero;

  btu_ctrl ctrl_i (
    .issueValid (issueValid),
    .cfKind     (cfKind),
    .rsEqRt     (rsEqRt),
    .rsNeg      (rsNeg),
    .rsZero     (rsZero),
    .destZero   (destZero),
    .strobe     (strobe)
  );

  btu_datapath #(
    .ADDR_W (ADDR_W), .OFF_W (OFF_W), .IDX_W (IDX_W), .REG_AW (REG_AW)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .instrPc    (instrPc),
    .instrField (instrField),
    .destIdx    (destIdx),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .strobe     (strobe),
    .rsEqRt     (rsEqRt),
    .rsNeg      (rsNeg),
    .rsZero     (rsZero),
    .destZero   (destZero),
    .targetPc   (targetPc),
    .linkIdx    (linkIdx),
    .linkVal    (linkVal),
    .alignFault (alignFault),
    .faultAddr  (faultAddr)
  );

  assign taken  = strobe.takeIt;
  assign linkEn = strobe.linkWr;
endmodule

// File: rtl/btu_checker.sv
module btu_checker
  import btu_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic [31:0] instrPc,
  input logic [3:0]  cfKind,
  input logic [31:0] rsVal,
  input logic        taken,
  input logic [31:0] targetPc,
  input logic        linkEn,
  input logic [4:0]  linkIdx,
  input logic [31:0] linkVal,
  input logic        alignFault
);
  logic [31:0] slotAddr;
  assign slotAddr = instrPc + 32'd4;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> (!taken && !linkEn && !alignFault));

  assert_none_inert_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfKind == CF_NONE) |-> (!taken && !linkEn));

  assert_jump_segment_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (cfKind == CF_JMP || cfKind == CF_JMP_LK)) |->
      (taken && targetPc[31:28] == slotAddr[31:28] && targetPc[1:0] == 2'b00));

  assert_reg_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (cfKind == CF_REG || cfKind == CF_REG_LK)) |->
      (taken && targetPc == rsVal));

  assert_link_fixed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (linkEn && cfKind != CF_REG_LK) |-> (linkIdx == 5'd31 && linkVal == instrPc + 32'd8));

  assert_fault_delayed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (cfKind == CF_REG || cfKind == CF_REG_LK) && rsVal[1:0] != 2'b00)
      |=> (!issueValid || alignFault));

  assert_fault_once_R10: assert property (@(posedge clk) disable iff (!rstN)
    (alignFault && !(cfKind == CF_REG || cfKind == CF_REG_LK)) |=> !alignFault);
endmodule

bind branch_target_unit btu_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .instrPc    (instrPc),
  .cfKind     (cfKind),
  .rsVal      (rsVal),
  .taken      (taken),
  .targetPc   (targetPc),
  .linkEn     (linkEn),
  .linkIdx    (linkIdx),
  .linkVal    (linkVal),
  .alignFault (alignFault)
);

// File: tb/branch_target_unit_tb.sv
module branch_target_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [31:0] instrPc;
  logic [3:0]  cfKind;
  logic [25:0] instrField;
  logic [4:0]  destIdx;
  logic [31:0] rsVal, rtVal;
  logic        taken, linkEn, alignFault;
  logic [31:0] targetPc, linkVal, faultAddr;
  logic [4:0]  linkIdx;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  branch_target_unit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrPc(instrPc),
    .cfKind(cfKind), .instrField(instrField), .destIdx(destIdx),
    .rsVal(rsVal), .rtVal(rtVal), .taken(taken), .targetPc(targetPc),
    .linkEn(linkEn), .linkIdx(linkIdx), .linkVal(linkVal),
    .alignFault(alignFault), .faultAddr(faultAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] relTarget(input logic [31:0] pc, input logic [15:0] off);
    return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic issue(input logic v, input logic [3:0] k, input logic [31:0] pc,
                       input logic [25:0] fld, input logic [4:0] rd,
                       input logic [31:0] rs, input logic [31:0] rt);
    @(negedge clk);
    issueValid = v; cfKind = k; instrPc = pc; instrField = fld;
    destIdx = rd; rsVal = rs; rtVal = rt;
    #1;
  endtask

  task automatic t_reset;
    issue(1'b0, 4'd1, 32'h100, 26'h0, 5'd0, 32'd5, 32'd5);
    check("R1 alignFault after reset", alignFault, 0);
    check("R1 taken idle", taken, 0);
    check("R1 linkEn idle", linkEn, 0);
    issue(1'b1, 4'd0, 32'h100, 26'h0, 5'd3, 32'd0, 32'd0);
    check("R2 kind0 taken", taken, 0);
    check("R2 kind0 link", linkEn, 0);
  endtask

  task automatic t_eq_ne;
    issue(1'b1, 4'd1, 32'h0040_0100, 26'h0004, 5'd0, 32'd7, 32'd7);
    check("R4 eq taken", taken, 1);
    check("R3 forward target", targetPc, relTarget(32'h0040_0100, 16'h0004));
    check("R3 forward value", targetPc, 32'h0040_0114);
    issue(1'b1, 4'd1, 32'h0040_0100, 26'h3FFFF, 5'd0, 32'd7, 32'd8);
    check("R4 eq differ", taken, 0);
    check("R3 backward target", targetPc, 32'h0040_0100);
    issue(1'b1, 4'd2, 32'h0040_0200, 26'h8000, 5'd0, 32'd7, 32'd8);
    check("R4 ne taken", taken, 1);
    check("R3 min offset", targetPc, relTarget(32'h0040_0200, 16'h8000));
    issue(1'b1, 4'd2, 32'h0040_0200, 26'h0, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R4 ne equal", taken, 0);
  endtask

  task automatic t_zero_cmp;
    issue(1'b1, 4'd3, 32'h1000, 26'h1, 5'd0, 32'h8000_0000, 32'd0);
    check("R5 ltz min", taken, 1);
    issue(1'b1, 4'd3, 32'h1000, 26'h1, 5'd0, 32'd0, 32'd0);
    check("R5 ltz zero", taken, 0);
    issue(1'b1, 4'd4, 32'h1000, 26'h1, 5'd0, 32'd0, 32'd0);
    check("R5 lez zero", taken, 1);
    issue(1'b1, 4'd4, 32'h1000, 26'h1, 5'd0, 32'h7FFF_FFFF, 32'd0);
    check("R5 lez max", taken, 0);
    issue(1'b1, 4'd5, 32'h1000, 26'h1, 5'd0, 32'd0, 32'd0);
    check("R5 gtz zero", taken, 0);
    issue(1'b1, 4'd5, 32'h1000, 26'h1, 5'd0, 32'h7FFF_FFFF, 32'd0);
    check("R5 gtz max", taken, 1);
    issue(1'b1, 4'd5, 32'h1000, 26'h1, 5'd0, 32'h8000_0000, 32'd0);
    check("R5 gtz min", taken, 0);
    issue(1'b1, 4'd6, 32'h1000, 26'h1, 5'd0, 32'd0, 32'd0);
    check("R5 gez zero", taken, 1);
    issue(1'b1, 4'd6, 32'h1000, 26'h1, 5'd0, 32'hFFFF_FFFF, 32'd0);
    check("R5 gez neg", taken, 0);
  endtask

  task automatic t_jumps;
    issue(1'b1, 4'd9, 32'h0FFF_FFFC, 26'h123_4567, 5'd0, 32'd0, 32'd0);
    check("R6 jump taken", taken, 1);
    check("R6 segment of slot", targetPc, {4'h1, 26'h123_4567, 2'b00});
    issue(1'b1, 4'd10, 32'hF000_0040, 26'h000_0010, 5'd0, 32'd0, 32'd0);
    check("R6 jal target", targetPc, 32'hF000_0040);
    check("R8 jal idx", linkIdx, 31);
    check("R8 jal val", linkVal, 32'hF000_0048);
    check("R8 jal en", linkEn, 1);
    issue(1'b1, 4'd11, 32'h2000, 26'h0, 5'd0, 32'h0000_8000, 32'd0);
    check("R7 reg target", targetPc, 32'h0000_8000);
    check("R7 reg taken", taken, 1);
    check("R8 reg no link", linkEn, 0);
  endtask

  task automatic t_links;
    issue(1'b1, 4'd7, 32'h3000, 26'h0010, 5'd0, 32'd1, 32'd0);
    check("R8 bltzal not taken", taken, 0);
    check("R8 bltzal links", linkEn, 1);
    check("R8 bltzal idx", linkIdx, 31);
    check("R8 bltzal val", linkVal, 32'h3008);
    issue(1'b1, 4'd8, 32'h3000, 26'h0010, 5'd0, 32'd1, 32'd0);
    check("R8 bgezal taken", taken, 1);
    check("R8 bgezal val", linkVal, 32'h3008);
    issue(1'b1, 4'd12, 32'h4000, 26'h0, 5'd5, 32'h0000_1000, 32'd0);
    check("R9 jalr en", linkEn, 1);
    check("R9 jalr idx", linkIdx, 5);
    check("R9 jalr val", linkVal, 32'h4008);
    issue(1'b1, 4'd12, 32'h4000, 26'h0, 5'd0, 32'h0000_1000, 32'd0);
    check("R9 jalr rd0", linkEn, 0);
    check("R9 jalr rd0 taken", taken, 1);
  endtask

  task automatic t_fault;
    issue(1'b1, 4'd11, 32'h5000, 26'h0, 5'd0, 32'h0000_6002, 32'd0);
    check("R10 no fault in jump cycle", alignFault, 0);
    issue(1'b1, 4'd0, 32'h5004, 26'h0, 5'd0, 32'd0, 32'd0);
    check("R10 fault on slot", alignFault, 1);
    check("R10 fault addr", faultAddr, 32'h0000_6002);
    issue(1'b1, 4'd0, 32'h6000, 26'h0, 5'd0, 32'd0, 32'd0);
    check("R10 fault cleared", alignFault, 0);
    issue(1'b1, 4'd12, 32'h5000, 26'h0, 5'd4, 32'h0000_7001, 32'd0);
    issue(1'b0, 4'd0, 32'h0, 26'h0, 5'd0, 32'd0, 32'd0);
    check("R10 idle hides", alignFault, 0);
    issue(1'b0, 4'd0, 32'h0, 26'h0, 5'd0, 32'd0, 32'd0);
    issue(1'b1, 4'd1, 32'h5004, 26'h0, 5'd0, 32'd0, 32'd1);
    check("R10 fault kept over idle", alignFault, 1);
    check("R10 fault addr idle", faultAddr, 32'h0000_7001);
    issue(1'b1, 4'd11, 32'h5000, 26'h0, 5'd0, 32'h0000_8004, 32'd0);
    issue(1'b1, 4'd0, 32'h5004, 26'h0, 5'd0, 32'd0, 32'd0);
    check("R10 aligned no fault", alignFault, 0);
  endtask

  initial begin
    rstN = 1'b0; issueValid = 1'b0; instrPc = '0; cfKind = '0;
    instrField = '0; destIdx = '0; rsVal = '0; rtVal = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_eq_ne();
    t_zero_cmp();
    t_jumps();
    t_links();
    t_fault();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule